// File: doc/BRIEF.md
# Discrete-Time Leaky Spiking Neuron

This block is one neuron of a discrete-time spiking network. It advances once per network time step, when the step strobe is high for a clock cycle. All arithmetic is signed 16-bit fixed point, with 4 integer bits and 12 fraction bits. A real value r is encoded as int(r x 4096), with the fraction truncated.

At each step the neuron forms a new membrane potential from three parts:
- A leak term, which is the leak factor times the previous potential. This term is forced to zero when the neuron fired at the previous step.
- The sum of its synaptic weights. Each weight, indexed by source neuron and delay, is gated by whether that source spiked that many steps ago.
- An external current.

The result is saturated to the signed 16-bit range and registered. The spike output is set when the registered potential reaches the threshold of 1.0.

The block keeps only its own previous potential and previous spike. The surrounding network supplies the weight row and the delayed spike history on flat buses. A typical setting is a leak of 0.98 (4014) and a current of 0.2 (819).

Top module: `snn_neuron`

## Requirements
- R1: While rst_n is low at a rising clock edge, pot_o becomes 0 and spike_o becomes 0.
- R2: At a rising edge where step_i is low, pot_o and spike_o keep their values, whatever the other inputs do.
- R3: When spike_o is 0 at a step, the leak term is the signed product leak_i x pot_o shifted arithmetically right by 12 bits (rounding toward minus infinity).
- R4: When spike_o is 1 at a step, the leak term is zero, so the previous potential has no effect on the new one.
- R5: The weight for source j and delay d (d from 1 to N_DLY) sits in wgt_i bits [16*(j*N_DLY+d-1) +: 16]. It is added only when hist_i bit j*N_DLY+d-1 is 1, where that bit means source j spiked d steps ago.
- R6: The new potential is the exact signed sum of the leak term, every gated weight and cur_i. It is registered on the rising edge where step_i is high.
- R7: If that sum is above 32767 or below -32768, the potential is clamped to 32767 or -32768 respectively. It never wraps.
- R8: spike_o is 1 exactly when the registered potential, read as signed, is at least 4096 (1.0). This is evaluated on the saturated value.
- R9: With leak 4014 (0.98), current 819 (0.2) and no synaptic input, the potential after reset follows the recursion V = floor(4014*V/4096) + 819, restarting from 819 after each spike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Time-step strobe; one update per high cycle |
| leak_i | input | 16 | Leak factor, signed Q4.12 |
| cur_i | input | 16 | External current, signed Q4.12 |
| wgt_i | input | 16*N_SRC*N_DLY | Weight row, signed Q4.12 per entry, indexed by source and delay |
| hist_i | input | N_SRC*N_DLY | Delayed network spikes, one bit per source and delay |
| pot_o | output | 16 | Registered membrane potential, signed Q4.12 |
| spike_o | output | 1 | Registered spike of the latest step |

## Verification
The checker assumes the following about the inputs:
- step_i, leak_i, cur_i and hist_i are stable and known around each sampling edge.
- A weight counts only when its history bit is set.

Its closed-form properties hold only for steps where the history bus is all zeros. In those cases the new potential follows from the current alone, either because the neuron had just fired or because the leak factor was zero.

The stimulus is driven on falling edges, so inputs never change near a sampling edge. It mixes directed cases that hit the threshold edge, both saturation limits and the reset-after-spike path, with random steps whose leak, weights and history bits come from a fixed-seed generator. Idle cycles with changing inputs between steps exercise the hold behaviour.

// File: rtl/snn_pkg.sv
// Package: shared fixed-point constants for the spiking neuron.
// Assumes a two's-complement signed format with Q_FRAC fraction bits.
package snn_pkg;
    localparam int Q_W    = 16;
    localparam int Q_FRAC = 12;
    localparam int SRC_N  = 4;
    localparam int DLY_N  = 2;
endpackage

// File: rtl/snn_leak_path.sv
// Leak path: returns the decayed previous potential, or zero after a spike.
// Assumes leak and potential are signed Q(DW-FRAC).FRAC values; the output is
// sign-extended to SUM_W bits, wide enough that no precision is lost.
module snn_leak_path #(
    parameter int DW    = 16,
    parameter int FRAC  = 12,
    parameter int SUM_W = 36
) (
    input  logic [DW-1:0]           leak_i,
    input  logic [DW-1:0]           pot_i,
    input  logic                    fired_i,
    output logic signed [SUM_W-1:0] term_o
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    // Full-precision product followed by an arithmetic rescale.
    always_comb begin
        prod   = $signed(leak_i) * $signed(pot_i);
        scaled = prod >>> FRAC;
    end

    // Reset mechanism: a spike at the previous step cancels the leak term.
    always_comb begin
        if (fired_i) term_o = '0;
        else         term_o = SUM_W'(scaled);
    end
endmodule

// File: rtl/snn_syn_sum.sv
// Synaptic sum: gates every weight by its delayed spike bit and adds them.
// Assumes entry e = j*ND + (d-1) holds the weight for source j, delay d.
module snn_syn_sum #(
    parameter int DW    = 16,
    parameter int NS    = 4,
    parameter int ND    = 2,
    parameter int SUM_W = 36
) (
    input  logic [DW*NS*ND-1:0]     wgt_i,
    input  logic [NS*ND-1:0]        hist_i,
    output logic signed [SUM_W-1:0] sum_o
);
    localparam int NE = NS * ND;

    logic signed [SUM_W-1:0] gated [NE];

    // One gate per source/delay entry.
    for (genvar e = 0; e < NE; e++) begin : g_gate
        logic signed [DW-1:0] w_e;
        assign w_e      = $signed(wgt_i[e*DW +: DW]);
        assign gated[e] = hist_i[e] ? SUM_W'(w_e) : '0;
    end

    // Adder over all gated entries.
    always_comb begin
        sum_o = '0;
        for (int e = 0; e < NE; e++) sum_o = sum_o + gated[e];
    end
endmodule

// File: rtl/snn_sat_fire.sv
// Saturation and firing: clamps the wide sum to DW bits, compares to 1.0.
// Assumes the input is an exact signed sum; threshold is 1 << FRAC.
module snn_sat_fire #(
    parameter int DW    = 16,
    parameter int FRAC  = 12,
    parameter int SUM_W = 36
) (
    input  logic signed [SUM_W-1:0] sum_i,
    output logic [DW-1:0]           pot_o,
    output logic                    fire_o
);
    localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MIN_V = -(SUM_W'(64'sd1 <<< (DW - 1)));
    localparam logic signed [DW-1:0]    THR   = DW'(64'sd1 <<< FRAC);

    logic signed [DW-1:0] clamped;

    // Clamp to the signed range instead of wrapping.
    always_comb begin
        if (sum_i > MAX_V)      clamped = MAX_V[DW-1:0];
        else if (sum_i < MIN_V) clamped = MIN_V[DW-1:0];
        else                    clamped = sum_i[DW-1:0];
    end

    // Threshold comparison on the clamped potential.
    always_comb begin
        pot_o  = clamped;
        fire_o = (clamped >= THR);
    end
endmodule

// File: rtl/snn_neuron.sv
// Top: one discrete-time leaky spiking neuron with delayed synaptic input.
// Assumes one update per step_i pulse; holds only its last potential and spike.
module snn_neuron #(
    parameter int DW    = snn_pkg::Q_W,
    parameter int FRAC  = snn_pkg::Q_FRAC,
    parameter int N_SRC = snn_pkg::SRC_N,
    parameter int N_DLY = snn_pkg::DLY_N
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_i,
    input  logic [DW-1:0]             leak_i,
    input  logic [DW-1:0]             cur_i,
    input  logic [DW*N_SRC*N_DLY-1:0] wgt_i,
    input  logic [N_SRC*N_DLY-1:0]    hist_i,
    output logic [DW-1:0]             pot_o,
    output logic                      spike_o
);
    localparam int NE    = N_SRC * N_DLY;
    localparam int SUM_W = 2 * DW + $clog2(NE + 2) + 1;

    logic signed [SUM_W-1:0] leak_term;
    logic signed [SUM_W-1:0] syn_term;
    logic signed [SUM_W-1:0] total;
    logic [DW-1:0]           pot_next;
    logic                    fire_next;

    snn_leak_path #(.DW(DW), .FRAC(FRAC), .SUM_W(SUM_W)) u_leak (
        .leak_i  (leak_i),
        .pot_i   (pot_o),
        .fired_i (spike_o),
        .term_o  (leak_term)
    );

    snn_syn_sum #(.DW(DW), .NS(N_SRC), .ND(N_DLY), .SUM_W(SUM_W)) u_syn (
        .wgt_i  (wgt_i),
        .hist_i (hist_i),
        .sum_o  (syn_term)
    );

    // Combine leak, synapses and external current.
    always_comb total = leak_term + syn_term + SUM_W'($signed(cur_i));

    snn_sat_fire #(.DW(DW), .FRAC(FRAC), .SUM_W(SUM_W)) u_sat (
        .sum_i  (total),
        .pot_o  (pot_next),
        .fire_o (fire_next)
    );

    // State register: advance once per step strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pot_o   <= '0;
            spike_o <= 1'b0;
        end else if (step_i) begin
            pot_o   <= pot_next;
            spike_o <= fire_next;
        end
    end
endmodule

// File: rtl/snn_neuron_chk.sv
// Checker: temporal properties of the neuron, bound to every snn_neuron.
// Assumes inputs are stable around each rising edge.
module snn_neuron_chk #(
    parameter int DW    = 16,
    parameter int FRAC  = 12,
    parameter int N_SRC = 4,
    parameter int N_DLY = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      step_i,
    input logic [DW-1:0]             leak_i,
    input logic [DW-1:0]             cur_i,
    input logic [DW*N_SRC*N_DLY-1:0] wgt_i,
    input logic [N_SRC*N_DLY-1:0]    hist_i,
    input logic [DW-1:0]             pot_o,
    input logic                      spike_o
);
    localparam logic signed [DW-1:0] THR = DW'(64'sd1 <<< FRAC);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pot_o == '0 && !spike_o));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pot_o) && $stable(spike_o)));

    // R4
    fired_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && spike_o && hist_i == '0) |=> (pot_o == $past(cur_i)));

    // R6
    zero_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && leak_i == '0 && hist_i == '0) |=> (pot_o == $past(cur_i)));

    // R8
    spike_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (spike_o == ($signed(pot_o) >= THR)));
endmodule

bind snn_neuron snn_neuron_chk #(
    .DW(DW), .FRAC(FRAC), .N_SRC(N_SRC), .N_DLY(N_DLY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .leak_i(leak_i),
    .cur_i(cur_i), .wgt_i(wgt_i), .hist_i(hist_i),
    .pot_o(pot_o), .spike_o(spike_o)
);

// File: tb/snn_neuron_tb.sv
module snn_neuron_tb;
    localparam int DW = 16;
    localparam int NS = 4;
    localparam int ND = 2;
    localparam int NE = NS * ND;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step_i = 1'b0;
    logic [DW-1:0]     leak_i = '0;
    logic [DW-1:0]     cur_i = '0;
    logic [DW*NE-1:0]  wgt_i = '0;
    logic [NE-1:0]     hist_i = '0;
    logic [DW-1:0]     pot_o;
    logic              spike_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    longint mv = 0;   // bench model potential
    bit     mz = 0;   // bench model spike

    always #4 clk = ~clk;

    snn_neuron u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .leak_i(leak_i),
        .cur_i(cur_i), .wgt_i(wgt_i), .hist_i(hist_i),
        .pot_o(pot_o), .spike_o(spike_o)
    );

    function automatic longint sx16(input logic [15:0] x);
        return longint'($signed(x));
    endfunction

    // Expected next potential from the requirements (R3..R7).
    function automatic longint model_next();
        longint acc = 0;
        if (!mz) acc = (sx16(leak_i) * mv) >>> 12;
        for (int e = 0; e < NE; e++)
            if (hist_i[e]) acc += sx16(wgt_i[e*DW +: DW]);
        acc += sx16(cur_i);
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // One step; compares potential and spike afterwards.
    task automatic do_step(input string req);
        longint nv;
        nv = model_next();
        step_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step_i = 1'b0;
        mv = nv;
        mz = (nv >= 4096);
        chk(req, sx16(pot_o), mv);
        chk("R8", longint'(spike_o), longint'(mz));
    endtask

    task automatic set_w(input int e, input int v);
        wgt_i[e*DW +: DW] = DW'(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED1234);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", sx16(pot_o), 0);
        chk("R1", longint'(spike_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: default trajectory with no synaptic input
        leak_i = 16'd4014; cur_i = 16'd819;
        for (int k = 0; k < 12; k++) do_step("R9");

        // R2: idle cycles with changing inputs
        begin
            longint hv; longint hz;
            hv = sx16(pot_o); hz = longint'(spike_o);
            leak_i = 16'h7FFF; cur_i = 16'h7FFF; hist_i = '1;
            wgt_i = '1;
            repeat (3) @(negedge clk);
            chk("R2", sx16(pot_o), hv);
            chk("R2", longint'(spike_o), hz);
        end

        // R8 threshold edge: exactly 1.0 fires, one LSB below does not
        wgt_i = '0; hist_i = '0; leak_i = '0;
        cur_i = 16'd4095; do_step("R8");
        cur_i = 16'd4096; do_step("R8");
        // R4: after spike, a large leak has no effect
        leak_i = 16'h7FFF; cur_i = 16'd100; do_step("R4");
        // R3: negative potential decays with floor rounding
        leak_i = 16'd2048; cur_i = 16'hF001; do_step("R3");
        cur_i = '0; do_step("R3");

        // R5: single entry gated on and off
        leak_i = '0; cur_i = '0; wgt_i = '0;
        for (int e = 0; e < NE; e++) set_w(e, 100 * (e + 1));
        hist_i = 8'b0000_0100; do_step("R5");
        hist_i = 8'b1000_0001; do_step("R5");
        hist_i = '0; do_step("R5");

        // R7: saturation at both ends
        for (int e = 0; e < NE; e++) set_w(e, 32767);
        hist_i = '1; cur_i = 16'h7FFF; do_step("R7");
        for (int e = 0; e < NE; e++) set_w(e, -32768);
        leak_i = '0; cur_i = 16'h8000; do_step("R7");

        // R6: random steps
        for (int k = 0; k < 300; k++) begin
            leak_i = DW'($urandom);
            cur_i  = DW'($urandom_range(0, 8191) - 4096);
            for (int e = 0; e < NE; e++) set_w(e, int'($urandom_range(0, 12287)) - 6144);
            hist_i = NE'($urandom);
            do_step("R6");
            if (k % 37 == 0) begin
                repeat (2) @(negedge clk);
            end
        end

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", sx16(pot_o), 0);
        chk("R1", longint'(spike_o), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule